// File: doc/BRIEF.md
# OTG Reverse-Power Start Sequencer

This block decides when a battery charger's converter may begin sourcing power backwards onto the USB VBUS rail, and which of two external input switch pairs carries that power to its port. It watches digital condition flags (battery above the OTG rising threshold, battery over-voltage, VBUS below UVLO, thermistor in window, VBUS present), the switch-pair presence bits, host control bits (OTG enable, per-port drive enables, a drive-disable override) and a 1 ms tick. It produces a converter switching enable, a one-cycle ramp-start strobe and one gate-drive enable per switch pair.

The start-up path depends on which switch pairs were found at power-on. With no pair found, or with the override set, the converter starts a fixed number of millisecond ticks after OTG enable. With a pair found, the converter holds in a non-switching state until the host asks for a detected port. Moving power from one port to the other has to pass through a stop state. In that state VBUS must fall below the present level before the other port may start.

Top module: `otg_start_seq`

## Requirements
- R1: The presence bits `swFoundA`/`swFoundB` are sampled on the first clock edge after reset is released. Later changes on those pins have no effect until the next reset.
- R2: The block leaves idle only while `otgEnable`, `battAboveOtg` and `vbusBelowUvlo` are 1, `tempInWindow` is 1 and `battOverVolt` is 0. If any of these fails, no tick count makes `convEnable` rise.
- R3: With no pair present, the count starts on the clock edge that follows OTG enable with good conditions. `convEnable` rises on the edge that registers the `DELAY_TICKS`-th tick, and both gates stay low.
- R4: With only pair A present, the converter stays off until `drvEnableA` is set. `drvEnableB` has no effect. After the delay, `convEnable` and `gateAOn` rise together.
- R5: With both pairs present, either port's drive enable starts the delay. If both are set in the same cycle, port A is chosen. The two gates are never high at the same time.
- R6: With `drvDisable` at 1, presence is ignored. The sequence runs as in R3, and both gates stay low.
- R7: `rampStart` is high for exactly the first cycle in which `convEnable` is high. A gate enable is only high while `convEnable` is high.
- R8: If the enabling condition drops during the delay, the block returns to idle and the tick count is cleared. A later start needs the full `DELAY_TICKS` again.
- R9: While running, `otgEnable` going to 0, a battery over-voltage, the battery falling below threshold, or the temperature leaving its window turns off `convEnable` and both gates on the next edge. VBUS leaving the UVLO region does not stop a running converter.
- R10: While one port drives, the other port's enable is ignored. Clearing the active port's enable turns off the converter and gate on the next edge. The block stays stopped while `vbusPresent` is 1. After that, a set enable on the other port restarts through the full delay.
- R11: During reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| battAboveOtg | input | 1 | Battery above OTG rising threshold |
| battOverVolt | input | 1 | Battery over-voltage fault |
| vbusBelowUvlo | input | 1 | VBUS below its UVLO level |
| tempInWindow | input | 1 | Thermistor inside hot/cold window |
| vbusPresent | input | 1 | VBUS above the present level |
| swFoundA | input | 1 | Switch pair A detected (sampled after reset) |
| swFoundB | input | 1 | Switch pair B detected (sampled after reset) |
| otgEnable | input | 1 | Host OTG enable |
| drvEnableA | input | 1 | Host drive request for port A |
| drvEnableB | input | 1 | Host drive request for port B |
| drvDisable | input | 1 | Override: ignore presence, keep gates off |
| msTick | input | 1 | One-cycle pulse every millisecond |
| convEnable | output | 1 | Converter switching enable |
| rampStart | output | 1 | One-cycle VBUS ramp start strobe |
| gateAOn | output | 1 | Gate drive for switch pair A |
| gateBOn | output | 1 | Gate drive for switch pair B |

## Verification
Every output is registered. An input applied before a clock edge therefore shows its result right after that edge: a stop or a state change appears after one edge, and the start appears on the edge that registers the final tick. The bench drives inputs on the falling edge and queues the value each output must have after the next rising edge. A monitor compares the outputs one nanosecond after that rising edge, so every expectation lines up with the single register stage. Idle-cycle gaps between ticks show that only ticks advance the delay, and that a hold or stop state absorbs any number of cycles.

// File: rtl/otg_seq_pkg.sv
package otg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_DELAY,
    ST_RUN,
    ST_STOP
  } seqState_e;

  typedef enum logic [1:0] {
    PORT_NONE,
    PORT_A,
    PORT_B
  } portSel_e;

  typedef struct packed {
    logic     cntClr;
    logic     cntStep;
    logic     portLoad;
    portSel_e portNext;
    logic     goRun;
    logic     gateA;
    logic     gateB;
    logic     halt;
  } seqStrobe_t;

endpackage

// File: rtl/otg_seq_dp.sv
module otg_seq_dp
  import otg_seq_pkg::*;
#(
  parameter int DELAY_TICKS = 5,
  parameter int NUM_PORTS   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       swFoundA,
  input  logic       swFoundB,
  input  seqStrobe_t strb,
  output logic       presA,
  output logic       presB,
  output logic       capDone,
  output logic       cntLast,
  output portSel_e   portSel,
  output logic       convEnable,
  output logic       rampStart,
  output logic       gateAOn,
  output logic       gateBOn
);

  localparam int CNT_W = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DELAY_TICKS - 1);

  logic [NUM_PORTS-1:0] swIn;
  logic [NUM_PORTS-1:0] presReg;
  logic [CNT_W-1:0]     tickCnt;
  logic                 capDoneReg;

  assign swIn = {swFoundB, swFoundA};

  // Presence latches: loaded once on the first edge after reset release.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pres
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        presReg[p] <= 1'b0;
      end else if (!capDoneReg) begin
        presReg[p] <= swIn[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capDoneReg <= 1'b0;
    end else begin
      capDoneReg <= 1'b1;
    end
  end

  // Millisecond delay counter.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strb.cntClr) begin
      tickCnt <= '0;
    end else if (strb.cntStep) begin
      tickCnt <= tickCnt + CNT_W'(1);
    end
  end

  // Selected port register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portSel <= PORT_NONE;
    end else if (strb.portLoad) begin
      portSel <= strb.portNext;
    end
  end

  // Output registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convEnable <= 1'b0;
      gateAOn    <= 1'b0;
      gateBOn    <= 1'b0;
      rampStart  <= 1'b0;
    end else begin
      rampStart <= strb.goRun;
      if (strb.goRun) begin
        convEnable <= 1'b1;
        gateAOn    <= strb.gateA;
        gateBOn    <= strb.gateB;
      end else if (strb.halt) begin
        convEnable <= 1'b0;
        gateAOn    <= 1'b0;
        gateBOn    <= 1'b0;
      end
    end
  end

  assign presA   = presReg[0];
  assign presB   = presReg[1];
  assign capDone = capDoneReg;
  assign cntLast = (tickCnt == CNT_END);

endmodule

// File: rtl/otg_seq_ctrl.sv
module otg_seq_ctrl
  import otg_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       battAboveOtg,
  input  logic       battOverVolt,
  input  logic       vbusBelowUvlo,
  input  logic       tempInWindow,
  input  logic       vbusPresent,
  input  logic       otgEnable,
  input  logic       drvEnableA,
  input  logic       drvEnableB,
  input  logic       drvDisable,
  input  logic       msTick,
  input  logic       presA,
  input  logic       presB,
  input  logic       capDone,
  input  logic       cntLast,
  input  portSel_e   portSel,
  output seqStrobe_t strb
);

  seqState_e st;
  seqState_e stNext;

  logic startOk;
  logic keepOk;
  logic directMode;
  logic wantA;
  logic wantB;
  logic portHeld;
  logic delayOk;

  // Start needs VBUS low; once running, VBUS is our own output and is not judged.
  assign startOk    = battAboveOtg && !battOverVolt && vbusBelowUvlo && tempInWindow;
  assign keepOk     = battAboveOtg && !battOverVolt && tempInWindow;
  assign directMode = drvDisable || (!presA && !presB);
  assign wantA      = presA && drvEnableA && !drvDisable;
  assign wantB      = presB && drvEnableB && !drvDisable;
  assign portHeld   = (portSel == PORT_NONE) ||
                      ((portSel == PORT_A) && drvEnableA) ||
                      ((portSel == PORT_B) && drvEnableB);
  assign delayOk    = otgEnable && startOk && portHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE;
    end else begin
      st <= stNext;
    end
  end

  always_comb begin
    stNext        = st;
    strb          = '0;
    strb.portNext = PORT_NONE;
    strb.cntClr   = (st != ST_DELAY);
    unique case (st)
      ST_IDLE: begin
        if (capDone && otgEnable && startOk) begin
          if (directMode) begin
            strb.portLoad = 1'b1;
            strb.portNext = PORT_NONE;
            stNext        = ST_DELAY;
          end else begin
            stNext = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (!otgEnable || !keepOk) begin
          stNext = ST_IDLE;
        end else if (directMode) begin
          strb.portLoad = 1'b1;
          strb.portNext = PORT_NONE;
          stNext        = ST_DELAY;
        end else if (wantA) begin
          strb.portLoad = 1'b1;
          strb.portNext = PORT_A;
          stNext        = ST_DELAY;
        end else if (wantB) begin
          strb.portLoad = 1'b1;
          strb.portNext = PORT_B;
          stNext        = ST_DELAY;
        end
      end
      ST_DELAY: begin
        if (!delayOk) begin
          strb.cntClr = 1'b1;
          stNext      = ST_IDLE;
        end else if (msTick) begin
          if (cntLast) begin
            strb.cntClr = 1'b1;
            strb.goRun  = 1'b1;
            strb.gateA  = (portSel == PORT_A) && !drvDisable;
            strb.gateB  = (portSel == PORT_B) && !drvDisable;
            stNext      = ST_RUN;
          end else begin
            strb.cntStep = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (!otgEnable || !keepOk) begin
          strb.halt = 1'b1;
          stNext    = ST_IDLE;
        end else if ((portSel != PORT_NONE) && (!portHeld || drvDisable)) begin
          strb.halt = 1'b1;
          stNext    = ST_STOP;
        end
      end
      ST_STOP: begin
        if (!otgEnable || !keepOk) begin
          stNext = ST_IDLE;
        end else if (!vbusPresent) begin
          stNext = ST_HOLD;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/otg_start_seq.sv
module otg_start_seq
  import otg_seq_pkg::*;
#(
  parameter int DELAY_TICKS = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic battAboveOtg,
  input  logic battOverVolt,
  input  logic vbusBelowUvlo,
  input  logic tempInWindow,
  input  logic vbusPresent,
  input  logic swFoundA,
  input  logic swFoundB,
  input  logic otgEnable,
  input  logic drvEnableA,
  input  logic drvEnableB,
  input  logic drvDisable,
  input  logic msTick,
  output logic convEnable,
  output logic rampStart,
  output logic gateAOn,
  output logic gateBOn
);

  seqStrobe_t strb;
  portSel_e   portSel;
  logic       presA;
  logic       presB;
  logic       capDone;
  logic       cntLast;

  otg_seq_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .battAboveOtg (battAboveOtg),
    .battOverVolt (battOverVolt),
    .vbusBelowUvlo(vbusBelowUvlo),
    .tempInWindow (tempInWindow),
    .vbusPresent  (vbusPresent),
    .otgEnable    (otgEnable),
    .drvEnableA   (drvEnableA),
    .drvEnableB   (drvEnableB),
    .drvDisable   (drvDisable),
    .msTick       (msTick),
    .presA        (presA),
    .presB        (presB),
    .capDone      (capDone),
    .cntLast      (cntLast),
    .portSel      (portSel),
    .strb         (strb)
  );

  otg_seq_dp #(
    .DELAY_TICKS(DELAY_TICKS),
    .NUM_PORTS  (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .swFoundA  (swFoundA),
    .swFoundB  (swFoundB),
    .strb      (strb),
    .presA     (presA),
    .presB     (presB),
    .capDone   (capDone),
    .cntLast   (cntLast),
    .portSel   (portSel),
    .convEnable(convEnable),
    .rampStart (rampStart),
    .gateAOn   (gateAOn),
    .gateBOn   (gateBOn)
  );

endmodule

// File: rtl/otg_start_seq_chk.sv
module otg_start_seq_chk (
  input logic clk,
  input logic rstN,
  input logic otgEnable,
  input logic battAboveOtg,
  input logic battOverVolt,
  input logic vbusBelowUvlo,
  input logic tempInWindow,
  input logic drvDisable,
  input logic convEnable,
  input logic rampStart,
  input logic gateAOn,
  input logic gateBOn
);

  assert_gate_needs_conv_R7: assert property (@(posedge clk) disable iff (!rstN)
    (gateAOn || gateBOn) |-> convEnable);

  assert_one_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(gateAOn && gateBOn));

  assert_ramp_first_R7: assert property (@(posedge clk) disable iff (!rstN)
    rampStart |-> (convEnable && !$past(convEnable)));

  assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    (convEnable && (battOverVolt || !battAboveOtg || !tempInWindow)) |=> !convEnable);

  assert_otg_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !otgEnable |=> (!convEnable && !gateAOn && !gateBOn));

  assert_start_ok_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convEnable) |-> $past(otgEnable && battAboveOtg && !battOverVolt &&
                                vbusBelowUvlo && tempInWindow));

  assert_override_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(convEnable) && $past(drvDisable)) |-> (!gateAOn && !gateBOn));

endmodule

bind otg_start_seq otg_start_seq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .otgEnable    (otgEnable),
  .battAboveOtg (battAboveOtg),
  .battOverVolt (battOverVolt),
  .vbusBelowUvlo(vbusBelowUvlo),
  .tempInWindow (tempInWindow),
  .drvDisable   (drvDisable),
  .convEnable   (convEnable),
  .rampStart    (rampStart),
  .gateAOn      (gateAOn),
  .gateBOn      (gateBOn)
);

// File: tb/otg_start_seq_tb.sv
`timescale 1ns/1ps
module otg_start_seq_tb;

  localparam int DT = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic battAboveOtg = 1'b1, battOverVolt = 1'b0, vbusBelowUvlo = 1'b1;
  logic tempInWindow = 1'b1, vbusPresent = 1'b0;
  logic swFoundA = 1'b0, swFoundB = 1'b0;
  logic otgEnable = 1'b0, drvEnableA = 1'b0, drvEnableB = 1'b0;
  logic drvDisable = 1'b0, msTick = 1'b0;
  logic convEnable, rampStart, gateAOn, gateBOn;

  typedef struct {
    logic  conv;
    logic  ramp;
    logic  ga;
    logic  gb;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int runCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  otg_start_seq #(.DELAY_TICKS(DT)) u_dut (
    .clk(clk), .rstN(rstN),
    .battAboveOtg(battAboveOtg), .battOverVolt(battOverVolt),
    .vbusBelowUvlo(vbusBelowUvlo), .tempInWindow(tempInWindow),
    .vbusPresent(vbusPresent), .swFoundA(swFoundA), .swFoundB(swFoundB),
    .otgEnable(otgEnable), .drvEnableA(drvEnableA), .drvEnableB(drvEnableB),
    .drvDisable(drvDisable), .msTick(msTick),
    .convEnable(convEnable), .rampStart(rampStart),
    .gateAOn(gateAOn), .gateBOn(gateBOn)
  );

  // Driver: queue the outputs expected after the coming rising edge.
  task automatic cyc(input logic c, input logic r, input logic a, input logic b,
                     input string tag);
    expItem_t it;
    it.conv = c; it.ramp = r; it.ga = a; it.gb = b; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      msTick = 1'b1;
      cyc(0, 0, 0, 0, tag);
      msTick = 1'b0;
      cyc(0, 0, 0, 0, tag);
    end
  endtask

  task automatic lastTick(input logic a, input logic b, input string tag);
    msTick = 1'b1;
    cyc(1, 1, a, b, {tag, " R7 start"});
    msTick = 1'b0;
    cyc(1, 0, a, b, {tag, " R7 ramp ends"});
  endtask

  task automatic doReset(input logic pa, input logic pb);
    rstN = 1'b0;
    otgEnable = 0; drvEnableA = 0; drvEnableB = 0; drvDisable = 0; msTick = 0;
    battAboveOtg = 1; battOverVolt = 0; vbusBelowUvlo = 1; tempInWindow = 1;
    vbusPresent = 0;
    swFoundA = pa; swFoundB = pb;
    cyc(0, 0, 0, 0, "R11 in reset");
    cyc(0, 0, 0, 0, "R11 in reset");
    rstN = 1'b1;
    cyc(0, 0, 0, 0, "R1 capture edge");
    swFoundA = ~pa; swFoundB = ~pb;   // R1: must be ignored from now on
  endtask

  // Monitor: compare one ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        runCnt++;
        if ({convEnable, rampStart, gateAOn, gateBOn} !== {it.conv, it.ramp, it.ga, it.gb}) begin
          failCnt++;
          $display("FAIL %s: actual conv=%0b ramp=%0b gA=%0b gB=%0b expected conv=%0b ramp=%0b gA=%0b gB=%0b",
                   it.tag, convEnable, rampStart, gateAOn, gateBOn,
                   it.conv, it.ramp, it.ga, it.gb);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // --- No pairs found: start conditions and direct start (R2, R3, R1)
    doReset(0, 0);
    otgEnable = 1; vbusBelowUvlo = 0;
    cyc(0, 0, 0, 0, "R2 vbus high blocks");
    ticks(DT + 1, "R2 vbus high blocks");
    vbusBelowUvlo = 1; battOverVolt = 1;
    cyc(0, 0, 0, 0, "R2 overvolt blocks");
    ticks(DT + 1, "R2 overvolt blocks");
    battOverVolt = 0; drvEnableA = 1;
    cyc(0, 0, 0, 0, "R3 enter delay");
    ticks(DT - 1, "R3 counting");
    lastTick(0, 0, "R3 direct");
    // --- Running: VBUS up is tolerated, fault stops (R9)
    vbusBelowUvlo = 0;
    cyc(1, 0, 0, 0, "R9 vbus up keeps running");
    battOverVolt = 1;
    cyc(0, 0, 0, 0, "R9 overvolt stops");
    // --- Abort during count clears the counter (R8)
    battOverVolt = 0; vbusBelowUvlo = 1;
    cyc(0, 0, 0, 0, "R8 re-enter delay");
    ticks(3, "R8 partial count");
    tempInWindow = 0;
    cyc(0, 0, 0, 0, "R8 abort");
    tempInWindow = 1;
    cyc(0, 0, 0, 0, "R8 re-enter delay");
    ticks(DT - 1, "R8 full count needed");
    lastTick(0, 0, "R8 restart");
    otgEnable = 0;
    cyc(0, 0, 0, 0, "R9 otg clear stops");

    // --- Only pair A found (R4, R1)
    doReset(1, 0);
    otgEnable = 1;
    cyc(0, 0, 0, 0, "R4 hold");
    drvEnableB = 1;
    cyc(0, 0, 0, 0, "R4 port B ignored");
    ticks(DT + 1, "R4 port B ignored");
    drvEnableB = 0; drvEnableA = 1;
    cyc(0, 0, 0, 0, "R4 port A request");
    ticks(DT - 1, "R4 counting");
    lastTick(1, 0, "R4 port A");

    // --- Both pairs: tie, swap through stop (R5, R10)
    doReset(1, 1);
    otgEnable = 1;
    cyc(0, 0, 0, 0, "R5 hold");
    drvEnableA = 1; drvEnableB = 1;
    cyc(0, 0, 0, 0, "R5 tie request");
    ticks(DT - 1, "R5 counting");
    lastTick(1, 0, "R5 tie picks A");
    vbusPresent = 1;
    cyc(1, 0, 1, 0, "R10 B ignored while A drives");
    cyc(1, 0, 1, 0, "R10 B ignored while A drives");
    drvEnableA = 0;
    cyc(0, 0, 0, 0, "R10 A cleared stops");
    cyc(0, 0, 0, 0, "R10 stop while vbus present");
    ticks(DT + 1, "R10 stop while vbus present");
    vbusPresent = 0;
    cyc(0, 0, 0, 0, "R10 back to hold");
    cyc(0, 0, 0, 0, "R10 B request");
    ticks(DT - 1, "R10 counting");
    lastTick(0, 1, "R10 port B");

    // --- Override (R6)
    doReset(1, 1);
    drvDisable = 1; drvEnableA = 1; otgEnable = 1;
    cyc(0, 0, 0, 0, "R6 direct delay");
    ticks(DT - 1, "R6 counting");
    lastTick(0, 0, "R6 override gates off");

    cyc(1, 0, 0, 0, "R6 steady");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule